// File: doc/BRIEF.md
# Addressed Packet Router and Classifier

This block sits between a local serial host and a radio receive path and decides where each incoming packet belongs. Both sources feed one byte-wide ingress port, and a source tag travels with every byte. The block parses the length byte, the 16-bit destination and source identifiers and the command byte. It then classifies the packet as belonging to local command processing, the radio transmit path or the host, or as dropped. Serial framing, the radio physical layer and the execution of commands are handled elsewhere.

The block holds the station's own 16-bit identifier and a promiscuous watch flag. When a packet's end marker is accepted, the parsed header and the routing decision are presented for one cycle. Data bytes that follow the command byte are forwarded unchanged, tagged with their route, as they arrive. Malformed packets and packets with an unknown command produce a one-cycle error pulse instead of a decision.

Top module: `pkt_router`

## Requirements
- R1: A packet is framed by `in_sop` on its first byte and `in_eop` on its last. Byte 0 is the count of bytes after it. Bytes 1-2 are the destination ID, high byte first. Bytes 3-4 are the source ID, high byte first. Byte 5 is the command. For a well-formed packet, `done` pulses one cycle after the end byte is accepted, and `hdr_dst`, `hdr_src`, `hdr_cmd`, `hdr_len` and `hdr_from_radio` (1 = radio, 0 = host) carry the parsed header.
- R2: A host packet (`in_src`=0) whose destination equals the own ID reports route LOCAL (code 1).
- R3: A host packet with any other destination reports route RADIO (code 2), whatever its command.
- R4: A radio packet (`in_src`=1) addressed to the own ID reports LOCAL if its command is in 0xA0-0xBF, and HOST (code 3) if its command is in 0xC0-0xDF.
- R5: A radio packet with destination 0 reports HOST, whatever its command.
- R6: A radio packet with a non-zero destination that differs from the own ID reports DROP (code 0) while watch mode is off, and HOST while it is on.
- R7: A packet routed LOCAL with command 0xA6 sets `watch_on`, and one with 0xA7 clears it. The change appears in the same cycle as that packet's `done`. Reset clears the flag.
- R8: A length byte below 5 or above 124 gives an `err` pulse one cycle after the end byte and no `done`.
- R9: An end byte at any position other than the one the length byte gives, or a new start byte while a packet is open, gives an `err` pulse. Bytes with `in_valid` but no open packet and no start marker are ignored.
- R10: A packet addressed to the own ID whose command lies outside 0xA0-0xDF gives an `err` pulse, no `done`, and no forwarded data.
- R11: Each data byte (position 6 up to the length) of a packet whose route is not DROP appears on `out_data` with `out_valid` and `out_route` one cycle after it is accepted. Header bytes never appear there.
- R12: After reset the own ID equals the DEFAULT_ID parameter (2), and `done`, `err`, `out_valid` and `watch_on` are low. `id_we` loads `id_wdata` into the own ID at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Ingress byte valid |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| in_src | input | 1 | Byte origin: 0 host, 1 radio |
| in_data | input | 8 | Ingress byte |
| id_we | input | 1 | Load own ID |
| id_wdata | input | 16 | New own ID |
| own_id | output | 16 | Current own ID |
| watch_on | output | 1 | Watch mode flag |
| done | output | 1 | Decision valid pulse |
| err | output | 1 | Malformed or rejected packet pulse |
| route | output | 2 | 0 drop, 1 local, 2 radio, 3 host |
| hdr_dst | output | 16 | Parsed destination ID |
| hdr_src | output | 16 | Parsed source ID |
| hdr_cmd | output | 8 | Parsed command |
| hdr_len | output | 8 | Parsed length byte |
| hdr_from_radio | output | 1 | Packet came from the radio |
| out_valid | output | 1 | Forwarded data byte valid |
| out_data | output | 8 | Forwarded data byte |
| out_route | output | 2 | Route of the forwarded byte |

## Verification
Every result of this block is due exactly one clock edge after the byte that causes it. `done`, `err` and the header follow the end byte, forwarded data follows each data byte, and the watch flag changes in the same cycle as the deciding packet's `done`. The bench drives one byte per falling edge. In the same step it advances a behavioural model that keeps the open packet as a byte queue, and it compares every output with the model's prediction at the next falling edge, one register stage later. Idle gaps inside packets, abandoned packets and length boundaries shift no result by more than that one stage.

// File: rtl/pkt_router_pkg.sv
package pkt_router_pkg;

    localparam int BYTE_W   = 8;
    localparam int ID_W     = 16;
    localparam int CMD_IDX  = 5;            // position of the command byte
    localparam int DATA_IDX = CMD_IDX + 1;  // first data byte

    typedef enum logic [1:0] {
        ROUTE_DROP  = 2'd0,
        ROUTE_LOCAL = 2'd1,
        ROUTE_RADIO = 2'd2,
        ROUTE_HOST  = 2'd3
    } route_e;

    typedef struct packed {
        logic [ID_W-1:0]   dst;
        logic [ID_W-1:0]   src;
        logic [BYTE_W-1:0] cmd;
        logic [BYTE_W-1:0] len;
        logic              from_radio;
    } hdr_t;

endpackage

// File: rtl/pkt_hdr_parser.sv
module pkt_hdr_parser
    import pkt_router_pkg::*;
#(
    parameter int MIN_LEN = 5,
    parameter int MAX_LEN = 124
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_src,
    input  logic [BYTE_W-1:0] in_data,
    output hdr_t              hdr_n,
    output logic              data_beat,
    output logic              end_ok,
    output logic              end_err
);

    localparam logic [BYTE_W-1:0] CNT_MAX = {BYTE_W{1'b1}};
    localparam logic [BYTE_W-1:0] LEN_LO  = BYTE_W'(MIN_LEN);
    localparam logic [BYTE_W-1:0] LEN_HI  = BYTE_W'(MAX_LEN);
    localparam logic [BYTE_W-1:0] D_FIRST = BYTE_W'(DATA_IDX);

    typedef struct packed {
        logic              active;
        logic [BYTE_W-1:0] cnt;
        hdr_t              hdr;
    } prs_t;

    prs_t s_d, s_q;
    logic [BYTE_W-1:0] idx;
    logic              take;
    logic              len_ok;

    always_comb begin
        s_d       = s_q;
        data_beat = 1'b0;
        end_ok    = 1'b0;
        end_err   = 1'b0;
        idx       = '0;
        take      = 1'b0;
        len_ok    = 1'b0;
        if (in_valid && in_sop) begin
            end_err            = s_q.active;   // open packet abandoned
            s_d.active         = 1'b1;
            s_d.hdr            = '0;
            s_d.hdr.len        = in_data;
            s_d.hdr.from_radio = in_src;
            take               = 1'b1;
        end else if (in_valid && s_q.active) begin
            idx  = s_q.cnt;
            take = 1'b1;
        end
        if (take) begin
            case (idx)
                8'd1:    s_d.hdr.dst[ID_W-1:BYTE_W] = in_data;
                8'd2:    s_d.hdr.dst[BYTE_W-1:0]    = in_data;
                8'd3:    s_d.hdr.src[ID_W-1:BYTE_W] = in_data;
                8'd4:    s_d.hdr.src[BYTE_W-1:0]    = in_data;
                8'd5:    s_d.hdr.cmd                = in_data;
                default: ;
            endcase
            s_d.cnt   = (idx == CNT_MAX) ? idx : idx + 1'b1;
            len_ok    = (s_d.hdr.len >= LEN_LO) && (s_d.hdr.len <= LEN_HI);
            data_beat = len_ok && (idx >= D_FIRST) && (idx <= s_d.hdr.len);
            if (in_eop) begin
                s_d.active = 1'b0;
                if (len_ok && idx == s_d.hdr.len) end_ok  = 1'b1;
                else                              end_err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hdr_n = s_d.hdr;

    // A single end byte is either well formed or malformed, never both.
    p_end_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(end_ok && end_err));

    // Data beats only happen once the whole header has been seen.
    p_beat_after_header_r11: assert property (@(posedge clk) disable iff (!rst_n)
        data_beat |-> (s_q.active && !in_sop));

endmodule

// File: rtl/pkt_route_decide.sv
module pkt_route_decide
    import pkt_router_pkg::*;
#(
    parameter logic [BYTE_W-1:0] REQ_LO = 8'hA0,
    parameter logic [BYTE_W-1:0] REQ_HI = 8'hBF,
    parameter logic [BYTE_W-1:0] REP_LO = 8'hC0,
    parameter logic [BYTE_W-1:0] REP_HI = 8'hDF
) (
    input  logic [ID_W-1:0]   dst,
    input  logic [BYTE_W-1:0] cmd,
    input  logic              from_radio,
    input  logic [ID_W-1:0]   my_id,
    input  logic              watch,
    output route_e            route,
    output logic              cmd_err
);

    logic is_req, is_rep, hit;

    always_comb begin
        is_req  = (cmd >= REQ_LO) && (cmd <= REQ_HI);
        is_rep  = (cmd >= REP_LO) && (cmd <= REP_HI);
        hit     = (dst == my_id);
        route   = ROUTE_DROP;
        cmd_err = 1'b0;
        if (!from_radio) begin
            if (hit) begin
                route   = ROUTE_LOCAL;
                cmd_err = !(is_req || is_rep);
            end else begin
                route   = ROUTE_RADIO;
            end
        end else if (dst == '0) begin
            route = ROUTE_HOST;
        end else if (hit) begin
            if (is_req)      route = ROUTE_LOCAL;
            else if (is_rep) route = ROUTE_HOST;
            else             cmd_err = 1'b1;
        end else if (watch) begin
            route = ROUTE_HOST;
        end
    end

endmodule

// File: rtl/pkt_router.sv
module pkt_router
    import pkt_router_pkg::*;
#(
    parameter logic [ID_W-1:0]   DEFAULT_ID = 16'd2,
    parameter int                MIN_LEN    = 5,
    parameter int                MAX_LEN    = 124,
    parameter logic [BYTE_W-1:0] CMD_WATCH  = 8'hA6,
    parameter logic [BYTE_W-1:0] CMD_NORMAL = 8'hA7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_src,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              id_we,
    input  logic [ID_W-1:0]   id_wdata,
    output logic [ID_W-1:0]   own_id,
    output logic              watch_on,
    output logic              done,
    output logic              err,
    output logic [1:0]        route,
    output logic [ID_W-1:0]   hdr_dst,
    output logic [ID_W-1:0]   hdr_src,
    output logic [BYTE_W-1:0] hdr_cmd,
    output logic [BYTE_W-1:0] hdr_len,
    output logic              hdr_from_radio,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic [1:0]        out_route
);

    typedef struct packed {
        logic [ID_W-1:0]   my_id;
        logic              watch;
        logic              done;
        logic              err;
        route_e            route;
        hdr_t              hdr;
        logic              ov;
        logic [BYTE_W-1:0] od;
        route_e            oroute;
    } top_t;

    top_t   r_d, r_q;
    hdr_t   hdr_n;
    logic   data_beat, end_ok, end_err;
    route_e route_n;
    logic   cmd_err;

    pkt_hdr_parser #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_parser (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .in_src    (in_src),
        .in_data   (in_data),
        .hdr_n     (hdr_n),
        .data_beat (data_beat),
        .end_ok    (end_ok),
        .end_err   (end_err)
    );

    pkt_route_decide u_decide (
        .dst        (hdr_n.dst),
        .cmd        (hdr_n.cmd),
        .from_radio (hdr_n.from_radio),
        .my_id      (r_q.my_id),
        .watch      (r_q.watch),
        .route      (route_n),
        .cmd_err    (cmd_err)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = end_err;
        r_d.ov   = 1'b0;
        if (end_ok) begin
            if (cmd_err) begin
                r_d.err = 1'b1;
            end else begin
                r_d.done  = 1'b1;
                r_d.route = route_n;
                r_d.hdr   = hdr_n;
                if (route_n == ROUTE_LOCAL && hdr_n.cmd == CMD_WATCH)  r_d.watch = 1'b1;
                if (route_n == ROUTE_LOCAL && hdr_n.cmd == CMD_NORMAL) r_d.watch = 1'b0;
            end
        end
        if (data_beat && !cmd_err && route_n != ROUTE_DROP) begin
            r_d.ov     = 1'b1;
            r_d.od     = in_data;
            r_d.oroute = route_n;
        end
        if (id_we) r_d.my_id = id_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.my_id <= DEFAULT_ID;
        end else begin
            r_q <= r_d;
        end
    end

    assign own_id         = r_q.my_id;
    assign watch_on       = r_q.watch;
    assign done           = r_q.done;
    assign err            = r_q.err;
    assign route          = r_q.route;
    assign hdr_dst        = r_q.hdr.dst;
    assign hdr_src        = r_q.hdr.src;
    assign hdr_cmd        = r_q.hdr.cmd;
    assign hdr_len        = r_q.hdr.len;
    assign hdr_from_radio = r_q.hdr.from_radio;
    assign out_valid      = r_q.ov;
    assign out_data       = r_q.od;
    assign out_route      = r_q.oroute;

    p_done_follows_eop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(in_valid && in_eop));

    p_host_never_dropped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !hdr_from_radio) |-> (route != ROUTE_DROP));

    p_broadcast_to_host_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && hdr_from_radio && hdr_dst == '0) |-> (route == ROUTE_HOST));

    p_watch_moves_on_local_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(watch_on) |-> (done && route == ROUTE_LOCAL));

    p_done_err_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    p_forward_not_dropped_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_route != ROUTE_DROP));

endmodule

// File: tb/test_pkt_router.sv
`timescale 1ns/1ps
module test_pkt_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_src = 1'b0;
    logic [7:0]  in_data = '0;
    logic        id_we = 1'b0;
    logic [15:0] id_wdata = '0;
    logic [15:0] own_id, hdr_dst, hdr_src;
    logic        watch_on, done, err, hdr_from_radio, out_valid;
    logic [1:0]  route, out_route;
    logic [7:0]  hdr_cmd, hdr_len, out_data;

    always #10 clk = ~clk;

    pkt_router i_pkt_router (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_src(in_src), .in_data(in_data), .id_we(id_we),
        .id_wdata(id_wdata), .own_id(own_id), .watch_on(watch_on), .done(done),
        .err(err), .route(route), .hdr_dst(hdr_dst), .hdr_src(hdr_src),
        .hdr_cmd(hdr_cmd), .hdr_len(hdr_len), .hdr_from_radio(hdr_from_radio),
        .out_valid(out_valid), .out_data(out_data), .out_route(out_route)
    );

    int checks = 0;
    int errors = 0;
    string cur = "R12";

    // reference model state
    logic [7:0]  mq[$];
    logic [7:0]  pq[$];
    bit          m_active = 0;
    bit          m_src = 0;
    bit          m_watch = 0;
    int          m_own = 2;
    // expected outputs for the next sample
    bit          e_done = 0, e_err = 0, e_ov = 0, e_fr = 0;
    int          e_route = 0, e_dst = 0, e_src = 0, e_cmd = 0, e_len = 0;
    int          e_od = 0, e_oroute = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk(cur, "done", int'(done), int'(e_done));
        chk(cur, "err", int'(err), int'(e_err));
        if (e_done) begin
            chk(cur, "route", int'(route), e_route);
            chk("R1", "hdr_dst", int'(hdr_dst), e_dst);
            chk("R1", "hdr_src", int'(hdr_src), e_src);
            chk("R1", "hdr_cmd", int'(hdr_cmd), e_cmd);
            chk("R1", "hdr_len", int'(hdr_len), e_len);
            chk("R1", "hdr_from_radio", int'(hdr_from_radio), int'(e_fr));
        end
        chk("R11", "out_valid", int'(out_valid), int'(e_ov));
        if (e_ov) begin
            chk("R11", "out_data", int'(out_data), e_od);
            chk("R11", "out_route", int'(out_route), e_oroute);
        end
        chk("R7", "watch_on", int'(watch_on), int'(m_watch));
        chk("R12", "own_id", int'(own_id), m_own);
    endtask

    // route codes: 0 drop, 1 local, 2 radio, 3 host
    task automatic classify(output int r, output bit cerr);
        int dst, cmd;
        bit req, rep;
        dst  = {mq[1], mq[2]};
        cmd  = mq[5];
        req  = cmd >= 'hA0 && cmd <= 'hBF;
        rep  = cmd >= 'hC0 && cmd <= 'hDF;
        r    = 0;
        cerr = 0;
        if (!m_src) begin
            if (dst == m_own) begin r = 1; cerr = !(req || rep); end
            else r = 2;
        end else if (dst == 0) r = 3;
        else if (dst == m_own) begin
            if (req) r = 1; else if (rep) r = 3; else cerr = 1;
        end else if (m_watch) r = 3;
    endtask

    task automatic model(input bit v, input bit s, input bit e, input bit src,
                         input logic [7:0] d, input bit we, input int wv);
        int idx, len, r;
        bit lok, cerr;
        e_done = 0; e_err = 0; e_ov = 0;
        if (v) begin
            if (s) begin
                if (m_active) e_err = 1;
                mq.delete();
                m_active = 1;
                m_src = src;
            end
            if (s || m_active) begin
                mq.push_back(d);
                idx = mq.size() - 1;
                len = mq[0];
                lok = len >= 5 && len <= 124;
                r = 0; cerr = 0;
                if (idx >= 5) classify(r, cerr);
                if (idx >= 6 && lok && idx <= len && !cerr && r != 0) begin
                    e_ov = 1; e_od = d; e_oroute = r;
                end
                if (e) begin
                    m_active = 0;
                    if (lok && idx == len) begin
                        if (cerr) e_err = 1;
                        else begin
                            e_done = 1; e_route = r;
                            e_dst = {mq[1], mq[2]}; e_src = {mq[3], mq[4]};
                            e_cmd = mq[5]; e_len = len; e_fr = m_src;
                            if (r == 1 && mq[5] == 8'hA6) m_watch = 1;
                            if (r == 1 && mq[5] == 8'hA7) m_watch = 0;
                        end
                    end else e_err = 1;
                end
            end
        end
        if (we) m_own = wv;
    endtask

    task automatic cyc(input bit v, input bit s, input bit e, input bit src,
                       input logic [7:0] d, input bit we = 0, input int wv = 0);
        @(negedge clk);
        compare();
        in_valid = v; in_sop = s; in_eop = e; in_src = src; in_data = d;
        id_we = we; id_wdata = 16'(wv);
        model(v, s, e, src, d, we, wv);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 8'h00);
    endtask

    task automatic build(input int lenb, input int dst, input int src, input int cmd, input int ndata);
        pq.delete();
        pq.push_back(8'(lenb));
        pq.push_back(8'(dst >> 8)); pq.push_back(8'(dst));
        pq.push_back(8'(src >> 8)); pq.push_back(8'(src));
        pq.push_back(8'(cmd));
        for (int i = 0; i < ndata; i++) pq.push_back(8'(i * 7 + ndata + 1));
    endtask

    // send pq; gap inserts one idle cycle after byte 2; no_eop leaves it open
    task automatic send(input bit src, input bit gap = 0, input bit no_eop = 0);
        for (int i = 0; i < pq.size(); i++) begin
            cyc(1, i == 0, (i == pq.size() - 1) && !no_eop, src, pq[i]);
            if (gap && i == 2) cyc(0, 0, 0, src, 8'h00);
        end
    endtask

    task automatic pkt(input bit src, input int dst, input int s, input int cmd, input int nd, input bit gap = 0);
        build(nd + 5, dst, s, cmd, nd);
        send(src, gap);
        idle(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur = "R12"; idle(3);                          // R12 reset state
        cur = "R2";  pkt(0, 2, 1, 'hA0, 0);            // R2 host to own id, local
        cur = "R2";  pkt(0, 2, 1, 'hC5, 3, 1);         // R2 reply cmd still local
        cur = "R3";  pkt(0, 'h0013, 2, 'hA0, 3);       // R3 other destination, radio
        cur = "R3";  pkt(0, 'h0000, 2, 'h12, 1);       // R3 any cmd to radio
        cur = "R4";  pkt(1, 2, 9, 'hA5, 2);            // R4 request, local
        cur = "R4";  pkt(1, 2, 9, 'hC4, 1);            // R4 reply, host
        cur = "R4";  pkt(1, 2, 9, 'hBF, 0);            // R4 upper request edge
        cur = "R5";  pkt(1, 0, 7, 'hC2, 0);            // R5 broadcast
        cur = "R5";  pkt(1, 0, 7, 'h05, 2);            // R5 broadcast odd cmd
        cur = "R6";  pkt(1, 'h55, 7, 'hC0, 2);         // R6 dropped, watch off
        cur = "R7";  pkt(0, 2, 1, 'hA6, 0);            // R7 watch on
        cur = "R6";  pkt(1, 'h55, 7, 'hC0, 2);         // R6 watched, host
        cur = "R7";  pkt(1, 2, 7, 'hA7, 0);            // R7 watch off from radio local
        cur = "R6";  pkt(1, 'h55, 7, 'hC0, 2);         // R6 dropped again
        cur = "R8";  build(4, 2, 1, 'hA0, 0); send(0); idle(2);   // R8 length 4
        cur = "R8";  build(125, 2, 1, 'hA0, 2); send(0); idle(2); // R8 length 125
        cur = "R9";  build(8, 2, 1, 'hA0, 0); send(0); idle(2);   // R9 early end
        cur = "R9";  build(5, 'h33, 1, 'hA0, 2); send(0); idle(2); // R9 late end
        cur = "R9";  build(7, 'h33, 1, 'hA0, 2); send(0, 0, 1);   // R9 open packet
        cur = "R9";  pkt(0, 'h33, 1, 'hA1, 1);                    // R9 restart on sop
        cur = "R9";  cyc(1, 0, 0, 0, 8'hAA); cyc(1, 0, 1, 0, 8'hBB); idle(2); // R9 stray bytes
        cur = "R10"; pkt(1, 2, 3, 'h90, 2);            // R10 radio bad cmd
        cur = "R10"; pkt(0, 2, 3, 'hE0, 2);            // R10 host bad cmd
        cur = "R12"; cyc(0, 0, 0, 0, 8'h00, 1, 'h1234); idle(1);  // R12 load id
        cur = "R12"; pkt(0, 'h1234, 2, 'hA0, 1);       // R12 new id local
        cur = "R12"; pkt(0, 2, 2, 'hA0, 1);            // R12 old id now radio
        cur = "R8";  pkt(0, 'h77, 2, 'hD1, 119);       // R8 max length valid
        cur = "R8";  pkt(1, 'h1234, 2, 'hDF, 0);       // R8 min length valid
        idle(3);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule